// File: doc/BRIEF.md
# Announcement Record and Playback Sequencer

This block is the sequencing logic of a telephone answering machine that keeps one spoken announcement of 4096 samples in a flash memory. A record request starts a whole-device erase of the flash. The sequencer waits until the flash reports that it is no longer busy. It then takes one sample from an analog-to-digital converter for each location and writes it through a bus buffer into flash addresses 0 through 4095, in order.

A play request reads the same locations in the same order. The word fetched by each read is loaded into a digital-to-analog converter in the following cycle, when the flash is driving the shared data bus. The sequencer never touches the data itself. It only moves the address, the flash controls, the converter load strobes and the buffer enable that decides who owns the bus. The flash array and both converters sit outside the block.

Top module: `announce_rec_ctrl`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle within one clock. Afterwards `fl_erase`, `fl_en`, `adc_ld`, `dac_ld` and `buf_en` are all 0. The reset also works in the middle of a sequence.
- R2: A record sequence begins with `fl_erase` high for exactly one cycle. This happens once per record sequence.
- R3: `fl_busy` is sampled starting in the cycle after the erase pulse. No flash write (`fl_en`=1 with `fl_rw`=1) happens while `fl_busy` is 1. Writing starts only after `fl_busy` reads 0.
- R4: Each recorded sample takes three cycles:
  - a cycle with `adc_ld`=1;
  - a write cycle with `fl_en`=1, `fl_rw`=1 (1 means write) and `buf_en`=1;
  - a loop-check cycle.
- R5: A record sequence issues exactly 4096 writes, to addresses 0, 1, … 4095 in that order. Each write stores the most recent converter sample. Afterwards the sequencer returns to idle.
- R6: A play sequence issues exactly 4096 reads (`fl_en`=1, `fl_rw`=0) to addresses 0 through 4095 in order, with `buf_en`=0 during every read. Afterwards it returns to idle.
- R7: `dac_ld` is high for one cycle immediately after each read cycle and at no other time. The converter therefore receives every stored word in address order.
- R8: When `rec_req` and `play_req` are both high in an idle cycle, the record sequence runs and no read is issued.
- R9: A request of either kind that arrives while a sequence is running is ignored. It causes no erase, write, read or converter load after the running sequence ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_req | input | 1 | Start a record sequence (sampled in idle) |
| play_req | input | 1 | Start a play sequence (sampled in idle) |
| fl_busy | input | 1 | Flash erase in progress |
| fl_addr | output | 12 | Flash word address |
| fl_rw | output | 1 | Flash access direction, 1 = write, 0 = read |
| fl_en | output | 1 | Flash access enable |
| fl_erase | output | 1 | Whole-device erase strobe |
| adc_ld | output | 1 | Analog-to-digital converter sample strobe |
| dac_ld | output | 1 | Digital-to-analog converter load strobe |
| buf_en | output | 1 | Drives the converter sample onto the flash data bus |

## Verification
The hardest case to create from the ports is a request that arrives while a sequence is already running. It can only be observed by its absence after the long run has ended.

The bench raises `play_req` in the middle of a 4096-sample recording and `rec_req` in the middle of a playback. It then confirms, after the block has gone quiet, that no extra reads, converter loads or erases appeared.

A reset that lands part-way through the write loop is the other case that is awkward to reach. The bench issues it by watching its own running count of write cycles.

// File: rtl/anrc_pkg.sv
package anrc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ER_PULSE,
        ST_ER_WAIT,
        ST_REC_SMP,
        ST_REC_WR,
        ST_REC_CHK,
        ST_PL_RD,
        ST_PL_DAC,
        ST_PL_CHK
    } seq_state_t;

    typedef struct packed {
        logic erase;
        logic adc_ld;
        logic buf_en;
        logic en;
        logic rw;      // 1 = write
        logic dac_ld;
        logic clr;     // clear address counter
        logic inc;     // advance address counter
    } seq_ctl_t;

    function automatic seq_ctl_t decode_ctl(seq_state_t st);
        seq_ctl_t c;
        c = '0;
        unique case (st)
            ST_IDLE:     c.clr    = 1'b1;
            ST_ER_PULSE: c.erase  = 1'b1;
            ST_REC_SMP:  c.adc_ld = 1'b1;
            ST_REC_WR: begin
                c.buf_en = 1'b1;
                c.en     = 1'b1;
                c.rw     = 1'b1;
                c.inc    = 1'b1;
            end
            ST_PL_RD:    c.en     = 1'b1;
            ST_PL_DAC: begin
                c.dac_ld = 1'b1;
                c.inc    = 1'b1;
            end
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/anrc_addr_ctr.sv
module anrc_addr_ctr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << ADDR_W;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign addr = cnt_q[ADDR_W-1:0];
    assign done = (cnt_q == LIMIT);

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    a_r5_clr_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/anrc_seq.sv
module anrc_seq
    import anrc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rec_req,
    input  logic     play_req,
    input  logic     busy,
    input  logic     cnt_done,
    output seq_ctl_t ctl
);
    seq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (rec_req)       st_d = ST_ER_PULSE;   // record wins
                else if (play_req) st_d = ST_PL_RD;
            end
            ST_ER_PULSE: st_d = ST_ER_WAIT;
            ST_ER_WAIT:  if (!busy) st_d = ST_REC_SMP;
            ST_REC_SMP:  st_d = ST_REC_WR;
            ST_REC_WR:   st_d = ST_REC_CHK;
            ST_REC_CHK:  st_d = cnt_done ? ST_IDLE : ST_REC_SMP;
            ST_PL_RD:    st_d = ST_PL_DAC;
            ST_PL_DAC:   st_d = ST_PL_CHK;
            ST_PL_CHK:   st_d = cnt_done ? ST_IDLE : ST_PL_RD;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign ctl = decode_ctl(st_q);

    a_r2_erase_single: assert property (@(posedge clk) disable iff (rst)
        ctl.erase |=> !ctl.erase);
    a_r3_hold_on_busy: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ER_WAIT && busy) |=> !ctl.en);
    a_r6_read_bus_free: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && !ctl.rw) |-> !ctl.buf_en);
    a_r7_dac_after_read: assert property (@(posedge clk) disable iff (rst)
        ctl.dac_ld |-> $past(ctl.en && !ctl.rw));
    a_r8_rec_priority: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && rec_req) |=> ctl.erase);
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> !ctl.erase);

endmodule

// File: rtl/announce_rec_ctrl.sv
module announce_rec_ctrl
    import anrc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_req,
    input  logic              play_req,
    input  logic              fl_busy,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_rw,
    output logic              fl_en,
    output logic              fl_erase,
    output logic              adc_ld,
    output logic              dac_ld,
    output logic              buf_en
);
    seq_ctl_t ctl;
    logic     cnt_done;

    anrc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .rec_req  (rec_req),
        .play_req (play_req),
        .busy     (fl_busy),
        .cnt_done (cnt_done),
        .ctl      (ctl)
    );

    anrc_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.clr),
        .inc  (ctl.inc),
        .addr (fl_addr),
        .done (cnt_done)
    );

    assign fl_rw    = ctl.rw;
    assign fl_en    = ctl.en;
    assign fl_erase = ctl.erase;
    assign adc_ld   = ctl.adc_ld;
    assign dac_ld   = ctl.dac_ld;
    assign buf_en   = ctl.buf_en;

    a_r4_write_uses_buffer: assert property (@(posedge clk) disable iff (rst)
        (fl_en && fl_rw) |-> (buf_en && $past(adc_ld)));

endmodule

// File: tb/test_announce_rec_ctrl.sv
`timescale 1ns/1ps
module test_announce_rec_ctrl;
    localparam int    AW = 12;
    localparam int    NW = 1 << AW;
    localparam int    ERASE_CYC = 40;
    localparam real   HALF = 2.5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rec_req = 1'b0, play_req = 1'b0;
    logic fl_busy;
    logic [AW-1:0] fl_addr;
    logic fl_rw, fl_en, fl_erase, adc_ld, dac_ld, buf_en;

    always #(HALF) clk = ~clk;

    announce_rec_ctrl #(.ADDR_W(AW)) i_announce_rec_ctrl (
        .clk(clk), .rst(rst), .rec_req(rec_req), .play_req(play_req),
        .fl_busy(fl_busy), .fl_addr(fl_addr), .fl_rw(fl_rw), .fl_en(fl_en),
        .fl_erase(fl_erase), .adc_ld(adc_ld), .dac_ld(dac_ld), .buf_en(buf_en)
    );

    // ---------------- environment models ----------------
    logic [15:0] mem [NW];
    logic [15:0] rd_q = '0;
    logic [11:0] adc_q = '0;
    int          adc_k = 0;
    logic        adc_clr = 1'b0;
    int          busy_cnt = 0;
    logic [15:0] bus;

    function automatic logic [11:0] smp(int k);
        return 12'((k * 37 + 5) & 12'hFFF);
    endfunction

    assign fl_busy = (busy_cnt != 0);
    assign bus = buf_en ? {4'h0, adc_q} : rd_q;

    always @(posedge clk) begin
        if (fl_erase) begin
            for (int i = 0; i < NW; i++) mem[i] <= 16'hFFFF;
            busy_cnt <= ERASE_CYC;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
        end
        if (fl_en && fl_rw) mem[fl_addr] <= bus;
        if (fl_en && !fl_rw) rd_q <= mem[fl_addr];
    end

    always @(posedge clk) begin
        if (adc_clr) adc_k <= 0;
        else if (adc_ld) begin
            adc_q <= smp(adc_k);
            adc_k <= adc_k + 1;
        end
    end

    // ---------------- port monitor ----------------
    logic        mon_clr = 1'b0;
    int er_cnt, adc_cnt, wr_cnt, rd_cnt, dac_cnt;
    int busy_err, bufw_err, bufr_err, wr_ord_err, rd_ord_err, dac_err;
    logic [AW-1:0] wr_next, rd_next;
    logic        prev_rd;
    logic [15:0] dac_val [NW];

    always @(posedge clk) begin
        if (mon_clr) begin
            er_cnt <= 0; adc_cnt <= 0; wr_cnt <= 0; rd_cnt <= 0; dac_cnt <= 0;
            busy_err <= 0; bufw_err <= 0; bufr_err <= 0;
            wr_ord_err <= 0; rd_ord_err <= 0; dac_err <= 0;
            wr_next <= '0; rd_next <= '0; prev_rd <= 1'b0;
        end else begin
            if (fl_erase) er_cnt <= er_cnt + 1;
            if (adc_ld) adc_cnt <= adc_cnt + 1;
            if (fl_en && fl_rw) begin
                if (fl_busy) busy_err <= busy_err + 1;
                if (!buf_en) bufw_err <= bufw_err + 1;
                if (fl_addr != wr_next) wr_ord_err <= wr_ord_err + 1;
                wr_next <= wr_next + 1'b1;
                wr_cnt <= wr_cnt + 1;
            end
            if (fl_en && !fl_rw) begin
                if (buf_en) bufr_err <= bufr_err + 1;
                if (fl_addr != rd_next) rd_ord_err <= rd_ord_err + 1;
                rd_next <= rd_next + 1'b1;
                rd_cnt <= rd_cnt + 1;
            end
            if (dac_ld) begin
                if (!prev_rd) dac_err <= dac_err + 1;
                dac_val[dac_cnt[AW-1:0]] <= bus;
                dac_cnt <= dac_cnt + 1;
            end
            prev_rd <= fl_en && !fl_rw;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic clear_mon;
        @(negedge clk); mon_clr = 1'b1; adc_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0; adc_clr = 1'b0;
    endtask

    task automatic pulse(input bit r, input bit p);
        @(negedge clk); rec_req = r; play_req = p;
        @(negedge clk); rec_req = 1'b0; play_req = 1'b0;
    endtask

    task automatic wait_quiet(input string tag);
        int quiet;
        quiet = 0;
        for (int i = 0; i < 30000 && quiet < 8; i++) begin
            @(negedge clk);
            if (!fl_en && !fl_erase && !adc_ld && !dac_ld && !fl_busy) quiet++;
            else quiet = 0;
        end
        chk(quiet >= 8, {tag, " block returns to idle"}, quiet, 8);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({fl_erase, fl_en, adc_ld, dac_ld, buf_en} == 5'b0, "R1 reset outputs",
            int'({fl_erase, fl_en, adc_ld, dac_ld, buf_en}), 0);
    endtask

    task automatic t_record;
        int bad;
        clear_mon();
        pulse(1'b1, 1'b0);
        wait_quiet("R5");
        chk(er_cnt == 1, "R2 erase pulses per record", er_cnt, 1);
        chk(busy_err == 0, "R3 writes while busy", busy_err, 0);
        chk(adc_cnt == NW, "R4 converter samples", adc_cnt, NW);
        chk(bufw_err == 0, "R4 writes without buffer", bufw_err, 0);
        chk(wr_cnt == NW, "R5 write count", wr_cnt, NW);
        chk(wr_ord_err == 0, "R5 write address order", wr_ord_err, 0);
        bad = 0;
        for (int i = 0; i < NW; i++) if (mem[i] != {4'h0, smp(i)}) bad++;
        chk(bad == 0, "R5 stored samples", bad, 0);
    endtask

    task automatic t_play;
        int bad;
        clear_mon();
        pulse(1'b0, 1'b1);
        wait_quiet("R6");
        chk(rd_cnt == NW, "R6 read count", rd_cnt, NW);
        chk(rd_ord_err == 0, "R6 read address order", rd_ord_err, 0);
        chk(bufr_err == 0, "R6 buffer during read", bufr_err, 0);
        chk(wr_cnt == 0 && er_cnt == 0, "R6 no write or erase", wr_cnt + er_cnt, 0);
        chk(dac_cnt == NW, "R7 converter loads", dac_cnt, NW);
        chk(dac_err == 0, "R7 load not after read", dac_err, 0);
        bad = 0;
        for (int i = 0; i < NW; i++) if (dac_val[i] != {4'h0, smp(i)}) bad++;
        chk(bad == 0, "R7 played words", bad, 0);
    endtask

    task automatic t_ignore;
        clear_mon();
        pulse(1'b1, 1'b0);
        while (wr_cnt < 100) @(negedge clk);
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        wait_quiet("R9");
        chk(rd_cnt == 0 && dac_cnt == 0, "R9 play during record", rd_cnt + dac_cnt, 0);
        chk(er_cnt == 1 && wr_cnt == NW, "R9 record unaffected", wr_cnt, NW);
        clear_mon();
        pulse(1'b0, 1'b1);
        while (rd_cnt < 100) @(negedge clk);
        pulse(1'b1, 1'b0);
        wait_quiet("R9");
        chk(er_cnt == 0 && wr_cnt == 0, "R9 record during play", er_cnt + wr_cnt, 0);
        chk(rd_cnt == NW, "R9 play unaffected", rd_cnt, NW);
    endtask

    task automatic t_priority;
        clear_mon();
        pulse(1'b1, 1'b1);
        wait_quiet("R8");
        chk(er_cnt == 1, "R8 record chosen", er_cnt, 1);
        chk(rd_cnt == 0, "R8 no read issued", rd_cnt, 0);
    endtask

    task automatic t_midreset;
        clear_mon();
        pulse(1'b1, 1'b0);
        while (wr_cnt < 10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({fl_erase, fl_en, adc_ld, dac_ld, buf_en} == 5'b0, "R1 reset mid record",
            int'({fl_erase, fl_en, adc_ld, dac_ld, buf_en}), 0);
        rst = 1'b0;
        repeat (ERASE_CYC + 5) @(negedge clk);
        chk(!fl_en && !adc_ld, "R1 stays idle after reset", int'(fl_en), 0);
    endtask

    initial begin
        t_reset();
        t_record();
        t_play();
        t_ignore();
        t_priority();
        t_midreset();
        finish_up();
    end

    initial begin
        #(HALF * 2 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end

endmodule